// File: doc/BRIEF.md
# Read Burst Truncation Command Scheduler

This block sits on the controller side of a double-data-rate SDRAM read path and turns a stream of requests into the single-data-rate command bus, one command slot per clock. A read request names a bank, a column, a count of wanted data pairs (one pair moves per clock) and how the burst should end. The scheduler places the READ and then, when the burst has to be cut, times a BURST TERMINATE or a PRECHARGE so that exactly the wanted pairs reach the bus. It also holds off writes until the read data and the bus turnaround are over, and it keeps a small per-bank model of which banks are open and which are still recovering from a precharge.

Requests enter through a valid/ready handshake. `req_ready` is a function of the presented request and the scheduler state. While `req_valid` is high and `req_ready` low, the requester must keep every request field stable. A request is consumed at a clock edge where both are high. A request that breaks a rule is consumed and answered by a NOP with `err_o` set; it is never retried. Burst length and CAS latency come from the `cfg_*` pins, which must only change while no read, write gap or precharge is in progress.

Top module: `rd_trunc_sched`

## Requirements
- R1: After reset, `cmd_o` is NOP, `err_o` is 0, every bank is closed, nothing is pending, and `req_ready` is high for a request that is not stalled.
- R2: `cmd_o` codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, BURST TERMINATE=4, PRECHARGE=5, and at most one command leaves per clock. `req_op` codes are read=0, write=1, activate=2. A consumed request appears on `cmd_o`, with its bank on `cmd_bank_o`, in the clock after the consuming edge. An ACTIVATE opens its bank.
- R3: `cfg_bl` selects burst length 2 (code 1 or 0), 4 (code 2) or 8 (code 3); `cfg_cl` selects CAS latency 2 (0) or 3 (1). For a read with end mode 0 (terminate), let x be the wanted pairs clamped to BL/2. If x is below BL/2, a BURST TERMINATE to the same bank is issued exactly x clocks after the READ.
- R4: A read whose clamped count equals BL/2 (always the case for burst length 2) gets no BURST TERMINATE; a request above BL/2 is clamped to BL/2.
- R5: With end mode 1 (precharge), a PRECHARGE to the read's bank is issued exactly x clocks after the READ, whether or not x is a full burst, and the bank becomes closed.
- R6: No ACTIVATE, READ or WRITE reaches a bank until TRP clocks after its PRECHARGE; such a request is stalled meanwhile.
- R7: A WRITE is issued no earlier than CL + x + TURN clocks after the last READ, which is one clock past the read's last data clock plus TURN idle clocks; a write presented earlier is stalled and then leaves in that exact clock.
- R8: READs may leave on consecutive clocks; a new READ cancels a still-pending BURST TERMINATE of the previous one.
- R9: With end mode 2 (auto precharge), the READ leaves with `cmd_ap_o` high, no terminate or precharge command follows, the bank is closed, and the next command to that bank comes no earlier than BL/2 + TRP clocks after the READ. Auto precharge with a clamped count below BL/2 is an error.
- R10: A read with zero pairs, a read or write to a closed bank, an activate to an open bank, an auto-precharge short read, or an unknown op is consumed and answered by a NOP with `err_o` high in that clock.
- R11: `req_ready` is low in the clock whose slot belongs to a scheduled terminate or precharge and while a precharge is pending, so a request presented there is delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl | input | 2 | Burst length code |
| cfg_cl | input | 1 | CAS latency select |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be consumed this clock |
| req_op | input | 2 | Request kind |
| req_end | input | 2 | Read end mode: terminate, precharge, auto precharge |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Column |
| req_pairs | input | PAIR_W | Wanted data pairs |
| cmd_o | output | 3 | Command code |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_col_o | output | COL_W | Command column |
| cmd_ap_o | output | 1 | Auto precharge flag on READ |
| err_o | output | 1 | Rejected request marker |

## Verification
The main sweep crosses every burst length and CAS latency with wanted pair counts from zero to above the longest burst and both explicit end modes, so the terminate offset, the full-burst case with no terminate, the clamp and the zero-pair rejection are each separated, and the write gap measured after each read tells the CAS latency and the turnaround term apart. The precharge-ending half of the sweep follows each read with an activate to the same bank, which measures both the precharge offset and the recovery time. Separate sequences put a second read one clock after a first whose terminate would land later (cancellation) or exactly in that clock (slot reservation), and exercise auto precharge and each rejection cause.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_BST = 3'd4,
    CMD_PRE = 3'd5
  } cmd_e;

  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_ACT = 2'd2;

  localparam logic [1:0] END_BST  = 2'd0;
  localparam logic [1:0] END_PRE  = 2'd1;
  localparam logic [1:0] END_AUTO = 2'd2;

  // pairs per full burst for a burst-length code
  function automatic logic [3:0] half_of(input logic [1:0] code);
    case (code)
      2'd2:    half_of = 4'd2;
      2'd3:    half_of = 4'd4;
      default: half_of = 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/rts_req_check.sv
module rts_req_check #(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int PAIR_W = 4
) (
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_end,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [PAIR_W-1:0] req_pairs,
  input  logic [1:0]        cfg_bl,
  input  logic [NB-1:0]     bank_open,
  input  logic [NB-1:0]     bank_free,
  input  logic              term_due,
  input  logic              pre_pending,
  input  logic              wr_blocked,
  output logic [PAIR_W-1:0] half,
  output logic [PAIR_W-1:0] pairs_eff,
  output logic              stall,
  output logic              is_err
);
  import rts_pkg::*;

  logic open_b;
  logic free_b;

  always_comb begin
    half      = PAIR_W'(half_of(cfg_bl));
    pairs_eff = (req_pairs > half) ? half : req_pairs;
    open_b    = bank_open[req_bank];
    free_b    = bank_free[req_bank];

    stall = term_due || pre_pending || !free_b;
    if (req_op == OP_WR && wr_blocked) stall = 1'b1;

    case (req_op)
      OP_RD:   is_err = (req_pairs == '0) || !open_b ||
                        (req_end == END_AUTO && pairs_eff != half);
      OP_WR:   is_err = !open_b;
      OP_ACT:  is_err = open_b;
      default: is_err = 1'b1;
    endcase
  end
endmodule

// File: rtl/rts_bank_state.sv
module rts_bank_state #(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int TRP    = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic              pre_en,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic              ap_en,
  input  logic [BANK_W-1:0] ap_bank,
  input  logic [CNT_W-1:0]  ap_hold,
  output logic [NB-1:0]     bank_open,
  output logic [NB-1:0]     bank_free
);
  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [CNT_W-1:0] rp_cnt;
    logic hit_act, hit_pre, hit_ap;

    assign hit_act = act_en && (act_bank == BANK_W'(g));
    assign hit_pre = pre_en && (pre_bank == BANK_W'(g));
    assign hit_ap  = ap_en  && (ap_bank  == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[g] <= 1'b0;
        rp_cnt       <= '0;
      end else begin
        if (hit_act)
          bank_open[g] <= 1'b1;
        else if (hit_pre || hit_ap)
          bank_open[g] <= 1'b0;

        if (hit_pre)
          rp_cnt <= CNT_W'(TRP);
        else if (hit_ap)
          rp_cnt <= ap_hold;
        else if (rp_cnt != '0)
          rp_cnt <= rp_cnt - CNT_W'(1);
      end
    end

    // a command loaded at this edge lands at least TRP clocks after the precharge
    assign bank_free[g] = (rp_cnt <= CNT_W'(1));
  end
endmodule

// File: rtl/rts_trunc_timer.sv
module rts_trunc_timer #(
  parameter int BANK_W = 2,
  parameter int PAIR_W = 4,
  parameter int TURN   = 1,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAIR_W-1:0] ld_pairs,
  input  logic [PAIR_W-1:0] half,
  input  logic              cl3,
  input  logic [1:0]        end_mode,
  input  logic [BANK_W-1:0] ld_bank,
  output logic              term_due,
  output logic              term_pre,
  output logic [BANK_W-1:0] term_bank,
  output logic              pre_pending,
  output logic              wr_blocked
);
  import rts_pkg::*;

  logic [PAIR_W-1:0] term_cnt;
  logic [CNT_W-1:0]  wr_cnt;
  logic [CNT_W-1:0]  lat;
  logic              need_term;

  assign lat       = cl3 ? CNT_W'(3) : CNT_W'(2);
  assign need_term = (end_mode != END_AUTO) &&
                     ((ld_pairs < half) || (end_mode == END_PRE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_cnt  <= '0;
      term_pre  <= 1'b0;
      term_bank <= '0;
      wr_cnt    <= '0;
    end else if (load) begin
      // a new read replaces whatever cut was still waiting
      term_cnt  <= need_term ? ld_pairs : '0;
      term_pre  <= (end_mode == END_PRE);
      term_bank <= ld_bank;
      wr_cnt    <= lat + CNT_W'(ld_pairs) + CNT_W'(TURN);
    end else begin
      if (term_cnt != '0) term_cnt <= term_cnt - PAIR_W'(1);
      if (wr_cnt != '0)   wr_cnt   <= wr_cnt - CNT_W'(1);
    end
  end

  assign term_due    = (term_cnt == PAIR_W'(1));
  assign pre_pending = (term_cnt != '0) && term_pre;
  assign wr_blocked  = (wr_cnt > CNT_W'(1));
endmodule

// File: rtl/rd_trunc_sched.sv
module rd_trunc_sched #(
  parameter int NB     = 4,
  parameter int COL_W  = 9,
  parameter int PAIR_W = 4,
  parameter int TRP    = 3,
  parameter int TURN   = 1,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_bl,
  input  logic              cfg_cl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_end,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [PAIR_W-1:0] req_pairs,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              cmd_ap_o,
  output logic              err_o
);
  import rts_pkg::*;

  localparam int CNT_W = $clog2(3 + 8 + TURN + TRP + 1) + 1;

  logic [NB-1:0]     bank_open, bank_free;
  logic [PAIR_W-1:0] half, pairs_eff;
  logic              stall, is_err, accept;
  logic              term_due, term_pre, pre_pending, wr_blocked;
  logic [BANK_W-1:0] term_bank;
  logic              load_rd, act_en, pre_en, ap_en;
  cmd_e              cmd_q;

  rts_req_check #(.NB(NB), .BANK_W(BANK_W), .PAIR_W(PAIR_W)) u_check (
    .req_op(req_op), .req_end(req_end), .req_bank(req_bank),
    .req_pairs(req_pairs), .cfg_bl(cfg_bl), .bank_open(bank_open),
    .bank_free(bank_free), .term_due(term_due), .pre_pending(pre_pending),
    .wr_blocked(wr_blocked), .half(half), .pairs_eff(pairs_eff),
    .stall(stall), .is_err(is_err)
  );

  assign req_ready = !stall;
  assign accept    = req_valid && !stall;
  assign load_rd   = accept && !is_err && (req_op == OP_RD);
  assign act_en    = accept && !is_err && (req_op == OP_ACT);
  assign pre_en    = term_due && term_pre;
  assign ap_en     = load_rd && (req_end == END_AUTO);

  rts_trunc_timer #(.BANK_W(BANK_W), .PAIR_W(PAIR_W), .TURN(TURN),
                    .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load_rd), .ld_pairs(pairs_eff),
    .half(half), .cl3(cfg_cl), .end_mode(req_end), .ld_bank(req_bank),
    .term_due(term_due), .term_pre(term_pre), .term_bank(term_bank),
    .pre_pending(pre_pending), .wr_blocked(wr_blocked)
  );

  rts_bank_state #(.NB(NB), .BANK_W(BANK_W), .TRP(TRP),
                   .CNT_W(CNT_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_bank(req_bank),
    .pre_en(pre_en), .pre_bank(term_bank), .ap_en(ap_en),
    .ap_bank(req_bank), .ap_hold(CNT_W'(half) + CNT_W'(TRP)),
    .bank_open(bank_open), .bank_free(bank_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_col_o  <= '0;
      cmd_ap_o   <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      cmd_q      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_col_o  <= '0;
      cmd_ap_o   <= 1'b0;
      err_o      <= 1'b0;
      if (term_due) begin
        cmd_q      <= term_pre ? CMD_PRE : CMD_BST;
        cmd_bank_o <= term_bank;
      end else if (accept) begin
        if (is_err) begin
          err_o <= 1'b1;
        end else begin
          cmd_bank_o <= req_bank;
          case (req_op)
            OP_RD: begin
              cmd_q     <= CMD_RD;
              cmd_col_o <= req_col;
              cmd_ap_o  <= (req_end == END_AUTO);
            end
            OP_WR: begin
              cmd_q     <= CMD_WR;
              cmd_col_o <= req_col;
            end
            default: cmd_q <= CMD_ACT;
          endcase
        end
      end
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/rts_chk.sv
module rts_chk #(
  parameter int NB  = 4,
  parameter int TRP = 3,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_bl,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic              cmd_ap_o,
  input logic              err_o
);
  logic [7:0] since_pre [NB];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n)
        since_pre[b] <= 8'(TRP);
      else if (cmd_o == 3'd5 && cmd_bank_o == BANK_W'(b))
        since_pre[b] <= 8'd1;
      else if (since_pre[b] < 8'(TRP))
        since_pre[b] <= since_pre[b] + 8'd1;
    end
  end

  // R10
  err_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> cmd_o == 3'd0);

  // R4
  bl2_no_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bl <= 2'd1) |-> cmd_o != 3'd4);

  // R7
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd3) |-> $past(cmd_o) != 3'd2);

  // R6
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o inside {3'd1, 3'd2, 3'd3}) |-> since_pre[cmd_bank_o] >= 8'(TRP));

  // R9
  ap_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ap_o |-> cmd_o == 3'd2);

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 3'd5);
endmodule

bind rd_trunc_sched rts_chk #(.NB(NB), .TRP(TRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cmd_o(cmd_o),
  .cmd_bank_o(cmd_bank_o), .cmd_ap_o(cmd_ap_o), .err_o(err_o)
);

// File: tb/sim_rd_trunc_sched.sv
module sim_rd_trunc_sched;
  localparam int CLK_P = 10;
  localparam int TRP   = 3;
  localparam int TURN  = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_bl = 2'd2;
  logic       cfg_cl = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0, req_end = 2'd0;
  logic [1:0] req_bank = 2'd0;
  logic [8:0] req_col = 9'd0;
  logic [3:0] req_pairs = 4'd0;
  logic [2:0] cmd_o;
  logic [1:0] cmd_bank_o;
  logic [8:0] cmd_col_o;
  logic       cmd_ap_o, err_o;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int t_rd = -1, t_bst = -1, t_pre = -1, t_wr = -1, t_act = -1, t_err = -1;

  always #(CLK_P/2) clk = ~clk;

  rd_trunc_sched #(.TRP(TRP), .TURN(TURN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_end(req_end), .req_bank(req_bank), .req_col(req_col),
    .req_pairs(req_pairs), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
    .cmd_col_o(cmd_col_o), .cmd_ap_o(cmd_ap_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      case (cmd_o)
        3'd1: t_act = cyc;
        3'd2: t_rd  = cyc;
        3'd3: t_wr  = cyc;
        3'd4: t_bst = cyc;
        3'd5: t_pre = cyc;
        default: ;
      endcase
      if (err_o) t_err = cyc;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] en,
                      input int bank, input int pairs, output int tacc);
    @(negedge clk);
    req_op = op; req_end = en; req_bank = 2'(bank);
    req_pairs = 4'(pairs); req_col = 9'(bank * 16 + pairs);
    req_valid = 1'b1;
    #(CLK_P/2 - 1);
    while (!req_ready) #(CLK_P);
    @(posedge clk);
    tacc = cyc;
  endtask

  task automatic wait_cycles(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int ta, tb, half, cl, x;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    wait_cycles(1);
    // R1 reset state
    check_eq("R1 cmd after reset", int'(cmd_o), 0);
    check_eq("R1 err after reset", int'(err_o), 0);
    check_eq("R1 ready after reset", int'(req_ready), 1);
    // R1 banks closed: read to bank 0 is rejected
    send(2'd0, 2'd0, 0, 1, ta);
    wait_cycles(1);
    check_eq("R1 read to closed bank err", t_err, ta + 1);

    // R2 activate
    send(2'd2, 2'd0, 0, 0, ta);
    wait_cycles(1);
    check_eq("R2 act code", int'(cmd_o), 1);
    check_eq("R2 act bank", int'(cmd_bank_o), 0);

    for (int c = 0; c < 2; c++) begin
      for (int b = 1; b < 4; b++) begin
        for (int p = 0; p < 6; p++) begin
          for (int m = 0; m < 2; m++) begin
            cfg_cl = c[0]; cfg_bl = 2'(b);
            half = (b == 1) ? 1 : ((b == 2) ? 2 : 4);
            cl = c + 2;
            x = (p > half) ? half : p;
            t_rd = -1; t_bst = -1; t_pre = -1; t_wr = -1; t_err = -1; t_act = -1;
            send(2'd0, 2'(m), 0, p, ta);
            if (p == 0) begin
              wait_cycles(1);
              check_eq("R10 zero pairs err", t_err, ta + 1);
              check_eq("R10 zero pairs no read", t_rd, -1);
            end else if (m == 0) begin
              send(2'd1, 2'd0, 0, 0, tb);
              wait_cycles(2);
              check_eq("R2 read slot", t_rd, ta + 1);
              check_eq("R7 write gap", t_wr - t_rd, cl + x + TURN);
              if (x < half)
                check_eq("R3 terminate offset", t_bst - t_rd, x);
              else
                check_eq("R4 no terminate on full burst", t_bst, -1);
            end else begin
              send(2'd2, 2'd0, 0, 0, tb);
              wait_cycles(2);
              check_eq("R5 precharge offset", t_pre - t_rd, x);
              check_eq("R6 act after precharge", t_act - t_pre, TRP);
              check_eq("R5 no terminate", t_bst, -1);
            end
          end
        end
      end
    end

    // R8 consecutive reads cancel a pending terminate
    cfg_bl = 2'd3; cfg_cl = 1'b0;
    send(2'd2, 2'd0, 1, 0, ta);
    wait_cycles(4);
    t_bst = -1;
    send(2'd0, 2'd0, 0, 2, ta);
    send(2'd0, 2'd0, 1, 4, tb);
    wait_cycles(8);
    check_eq("R8 back to back reads", tb - ta, 1);
    check_eq("R8 terminate cancelled", t_bst, -1);

    // R11 read presented in a reserved terminate slot waits one clock
    t_bst = -1;
    send(2'd0, 2'd0, 0, 1, ta);
    send(2'd0, 2'd0, 1, 4, tb);
    wait_cycles(8);
    check_eq("R11 terminate slot", t_bst, ta + 2);
    check_eq("R11 delayed read", tb - ta, 2);

    // R10 rejection causes
    t_err = -1;
    send(2'd0, 2'd0, 3, 2, ta);
    wait_cycles(1);
    check_eq("R10 read closed bank err", t_err, ta + 1);
    check_eq("R10 err cycle is nop", int'(cmd_o), 0);
    send(2'd1, 2'd0, 3, 0, ta);
    wait_cycles(1);
    check_eq("R10 write closed bank err", t_err, ta + 1);
    send(2'd2, 2'd0, 1, 0, ta);
    wait_cycles(1);
    check_eq("R10 act open bank err", t_err, ta + 1);
    send(2'd3, 2'd0, 1, 0, ta);
    wait_cycles(1);
    check_eq("R10 unknown op err", t_err, ta + 1);

    // R9 auto precharge
    cfg_bl = 2'd2;
    send(2'd0, 2'd2, 0, 1, ta);
    wait_cycles(1);
    check_eq("R9 short auto read err", t_err, ta + 1);
    t_bst = -1; t_pre = -1;
    send(2'd0, 2'd2, 0, 2, ta);
    wait_cycles(1);
    check_eq("R9 ap flag", int'(cmd_ap_o), 1);
    check_eq("R9 read code", int'(cmd_o), 2);
    send(2'd2, 2'd0, 0, 0, tb);
    wait_cycles(2);
    check_eq("R9 act after auto precharge", tb - ta, 2 + TRP);
    check_eq("R9 no terminate", t_bst, -1);
    check_eq("R9 no precharge cmd", t_pre, -1);

    summary();
    $finish;
  end
endmodule